// File: doc/BRIEF.md
# Segmented Page Map Register Bank

This block holds the page-translation table for an 8-bit CPU with a 16-bit address space. The table is split into segments of sixteen entries each. A small byte-wide register window on the I/O bus selects which segment is current, reads and writes the sixteen entries of that segment, loads a window offset byte and sets a control byte that carries map-enable, window-enable and boot-RAM flags.

While mapping is on, the upper nibble of the CPU address indexes the current segment and the stored entry comes out as the physical page number. While mapping is off, the nibble passes through with zero extension. Any write that flips the map-enable flag produces a single-cycle strobe, so the clock logic can recompute the CPU rate. A parameter chooses between a base configuration (four segments, 6-bit entries) and an extended one (eight segments, 8-bit entries).

Top module: `mmr_page_map`

## Requirements
- R1: After reset, map enable, window enable and boot-RAM are 0, the segment register is 0, every entry reads 0 and the rate strobe is low.
- R2: A bus write (sel and we high) to offsets 0x80..0x8F stores into entry number segment*16 + (offset & 0xF) on the next clock edge. A read of the same offsets returns that entry.
- R3: A bus write to offset 0x90 loads the segment register with the low 2 data bits (3 bits when EXTENDED=1). The upper data bits are dropped.
- R4: With EXTENDED=0 an entry keeps only data bits 5:0. On read, bits 7:6 come back as 0.
- R5: A bus write to offset 0x92 loads the 8-bit window offset, presented on win_offset_o.
- R6: A bus write to offset 0x93 sets boot_ram_o from data bit 0, win_en_o from bit 6 and map_en_o from bit 7.
- R7: A read of offset 0x93 returns 0x3E OR'd with boot-RAM at bit 0, window enable at bit 6 and map enable at bit 7.
- R8: clk_recalc_o is high for exactly the one cycle after an edge at which a 0x93 write changed map enable. It stays low after any 0x93 write that leaves map enable unchanged.
- R9: With map enable set, phys_page_o combinationally equals entry segment*16 + cpu_addr_hi_i, zero-extended to 8 bits. With map enable clear, it equals cpu_addr_hi_i zero-extended.
- R10: Reads of any other offset return 0xFF. Writes to any other offset, and any access with sel low, change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_sel_i | input | 1 | Register window access strobe |
| bus_we_i | input | 1 | Write when high, read when low |
| bus_addr_i | input | 8 | I/O offset within the window |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data (combinational on offset) |
| cpu_addr_hi_i | input | 4 | Upper nibble of CPU logical address |
| phys_page_o | output | 8 | Translated physical page |
| map_en_o | output | 1 | Mapping enabled |
| win_en_o | output | 1 | Window enabled |
| boot_ram_o | output | 1 | Boot-RAM mode |
| win_offset_o | output | 8 | Window offset register |
| clk_recalc_o | output | 1 | One-cycle request to recompute CPU clock rate |

## Verification
The assertions check on every cycle that the rate strobe fires when map enable changes, and only then. They also check that segment, window offset and entry writes land on the following edge, that pass-through pages never carry upper bits, and that the control readback always carries its fixed fill. The bench scenarios cover the rest. These are the aliasing of entries across segments, the truncation of the segment number and of 6-bit entries, and the translation result for chosen nibbles. They also cover the absence of a strobe on a rewrite of the same map value, and the fact that stray offsets and deselected writes leave every register intact.

// File: rtl/mmr_pkg.sv
package mmr_pkg;
  localparam logic [3:0] OFS_ENTRY_HI = 4'h8;
  localparam logic [7:0] OFS_SEG      = 8'h90;
  localparam logic [7:0] OFS_WIN      = 8'h92;
  localparam logic [7:0] OFS_CTRL     = 8'h93;
  localparam logic [7:0] CTRL_FILL    = 8'h3E;
  localparam int         CB_BOOT      = 0;
  localparam int         CB_WIN       = 6;
  localparam int         CB_MAP       = 7;

  typedef struct packed {
    logic map_en;
    logic win_en;
    logic boot_ram;
  } ctrl_t;
endpackage

// File: rtl/mmr_entry_file.sv
module mmr_entry_file #(
  parameter int SEG_W = 2,
  parameter int ENT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [SEG_W-1:0] seg_i,
  input  logic [3:0]       bus_idx_i,
  input  logic [7:0]       wr_data_i,
  input  logic [3:0]       lk_idx_i,
  output logic [ENT_W-1:0] bus_data_o,
  output logic [ENT_W-1:0] lk_data_o
);
  localparam int N_ENT = 16 << SEG_W;
  localparam int IDX_W = SEG_W + 4;

  logic [ENT_W-1:0] mem_q [N_ENT];
  logic [IDX_W-1:0] bus_ptr, lk_ptr;

  assign bus_ptr = {seg_i, bus_idx_i};
  assign lk_ptr  = {seg_i, lk_idx_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_ENT; i++) mem_q[i] <= '0;
    end else if (wr_en_i) begin
      mem_q[bus_ptr] <= wr_data_i[ENT_W-1:0];
    end
  end

  assign bus_data_o = mem_q[bus_ptr];
  assign lk_data_o  = mem_q[lk_ptr];

  // R2
  entry_write_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> mem_q[$past(bus_ptr)] == $past(wr_data_i[ENT_W-1:0]));
endmodule

// File: rtl/mmr_ctrl_regs.sv
module mmr_ctrl_regs
  import mmr_pkg::*;
#(
  parameter int SEG_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [7:0]       addr_i,
  input  logic [7:0]       wdata_i,
  output logic [SEG_W-1:0] seg_o,
  output logic [7:0]       win_off_o,
  output ctrl_t            ctrl_o,
  output logic             recalc_o
);
  logic [SEG_W-1:0] seg_q;
  logic [7:0]       win_q;
  ctrl_t            ctrl_q;
  logic             recalc_q;
  logic             wr_seg, wr_win, wr_ctrl;

  assign wr_seg  = wr_en_i && (addr_i == OFS_SEG);
  assign wr_win  = wr_en_i && (addr_i == OFS_WIN);
  assign wr_ctrl = wr_en_i && (addr_i == OFS_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_q    <= '0;
      win_q    <= '0;
      ctrl_q   <= '0;
      recalc_q <= 1'b0;
    end else begin
      if (wr_seg) seg_q <= wdata_i[SEG_W-1:0];
      if (wr_win) win_q <= wdata_i;
      if (wr_ctrl) begin
        ctrl_q.map_en   <= wdata_i[CB_MAP];
        ctrl_q.win_en   <= wdata_i[CB_WIN];
        ctrl_q.boot_ram <= wdata_i[CB_BOOT];
      end
      // rate recompute only on a real toggle of the map flag
      recalc_q <= wr_ctrl && (wdata_i[CB_MAP] != ctrl_q.map_en);
    end
  end

  assign seg_o     = seg_q;
  assign win_off_o = win_q;
  assign ctrl_o    = ctrl_q;
  assign recalc_o  = recalc_q;

  // R8
  recalc_on_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.map_en != $past(ctrl_q.map_en)) |-> recalc_q);
  // R8
  recalc_only_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recalc_q |-> (ctrl_q.map_en != $past(ctrl_q.map_en)));
  // R3
  seg_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_seg |=> seg_q == $past(wdata_i[SEG_W-1:0]));
  // R5
  win_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_win |=> win_q == $past(wdata_i));
endmodule

// File: rtl/mmr_page_map.sv
module mmr_page_map
  import mmr_pkg::*;
#(
  parameter bit EXTENDED = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bus_sel_i,
  input  logic       bus_we_i,
  input  logic [7:0] bus_addr_i,
  input  logic [7:0] bus_wdata_i,
  output logic [7:0] bus_rdata_o,
  input  logic [3:0] cpu_addr_hi_i,
  output logic [7:0] phys_page_o,
  output logic       map_en_o,
  output logic       win_en_o,
  output logic       boot_ram_o,
  output logic [7:0] win_offset_o,
  output logic       clk_recalc_o
);
  localparam int SEG_W = EXTENDED ? 3 : 2;
  localparam int ENT_W = EXTENDED ? 8 : 6;

  logic             bus_wr, entry_hit, entry_wr;
  logic [SEG_W-1:0] seg;
  ctrl_t            ctrl;
  logic [ENT_W-1:0] bus_ent, lk_ent;

  assign bus_wr    = bus_sel_i && bus_we_i;
  assign entry_hit = (bus_addr_i[7:4] == OFS_ENTRY_HI);
  assign entry_wr  = bus_wr && entry_hit;

  mmr_ctrl_regs #(.SEG_W(SEG_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (bus_wr),
    .addr_i    (bus_addr_i),
    .wdata_i   (bus_wdata_i),
    .seg_o     (seg),
    .win_off_o (win_offset_o),
    .ctrl_o    (ctrl),
    .recalc_o  (clk_recalc_o)
  );

  mmr_entry_file #(.SEG_W(SEG_W), .ENT_W(ENT_W)) u_entries (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (entry_wr),
    .seg_i      (seg),
    .bus_idx_i  (bus_addr_i[3:0]),
    .wr_data_i  (bus_wdata_i),
    .lk_idx_i   (cpu_addr_hi_i),
    .bus_data_o (bus_ent),
    .lk_data_o  (lk_ent)
  );

  always_comb begin
    bus_rdata_o = 8'hFF;
    if (entry_hit) begin
      bus_rdata_o = 8'(bus_ent);
    end else if (bus_addr_i == OFS_CTRL) begin
      bus_rdata_o = CTRL_FILL;
      bus_rdata_o[CB_MAP]  = ctrl.map_en;
      bus_rdata_o[CB_WIN]  = ctrl.win_en;
      bus_rdata_o[CB_BOOT] = ctrl.boot_ram;
    end
  end

  assign phys_page_o = ctrl.map_en ? 8'(lk_ent) : {4'h0, cpu_addr_hi_i};
  assign map_en_o    = ctrl.map_en;
  assign win_en_o    = ctrl.win_en;
  assign boot_ram_o  = ctrl.boot_ram;

  // R9
  passthru_page_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !map_en_o |-> phys_page_o[7:4] == 4'h0);
  // R7
  ctrl_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == OFS_CTRL) |-> bus_rdata_o[5:1] == 5'b11111);
  // R6
  ctrl_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr && bus_addr_i == OFS_CTRL) |=>
      (map_en_o == $past(bus_wdata_i[7]) && boot_ram_o == $past(bus_wdata_i[0])));
endmodule

// File: tb/mmr_page_map_test.sv
module mmr_page_map_test;
  localparam time CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bus_sel_i = 1'b0;
  logic       bus_we_i = 1'b0;
  logic [7:0] bus_addr_i = 8'h00;
  logic [7:0] bus_wdata_i = 8'h00;
  logic [7:0] bus_rdata_o;
  logic [3:0] cpu_addr_hi_i = 4'h0;
  logic [7:0] phys_page_o;
  logic       map_en_o, win_en_o, boot_ram_o, clk_recalc_o;
  logic [7:0] win_offset_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  mmr_page_map #(.EXTENDED(1'b0)) uut (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic sel = 1'b1);
    @(negedge clk_i);
    bus_sel_i = sel; bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk_i);
    bus_sel_i = 1'b0; bus_we_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    bus_addr_i = a; bus_we_i = 1'b0;
    #1 d = bus_rdata_o;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    check("R1 map", {7'd0, map_en_o}, 8'h00);
    check("R1 win", {7'd0, win_en_o}, 8'h00);
    check("R1 boot", {7'd0, boot_ram_o}, 8'h00);
    check("R1 strobe", {7'd0, clk_recalc_o}, 8'h00);
    rd(8'h93, v); check("R1 R7 ctrl read", v, 8'h3E);
    for (int i = 0; i < 16; i++) begin
      rd(8'h80 + 8'(i), v); check("R1 entry", v, 8'h00);
    end
  endtask

  task automatic t_entries;
    logic [7:0] v;
    wr(8'h83, 8'hFF);
    rd(8'h83, v); check("R4 mask to 6 bits", v, 8'h3F);
    wr(8'h90, 8'h02);
    rd(8'h83, v); check("R2 new segment empty", v, 8'h00);
    wr(8'h83, 8'h15);
    rd(8'h83, v); check("R2 seg2 entry", v, 8'h15);
    wr(8'h90, 8'h00);
    rd(8'h83, v); check("R2 seg0 kept", v, 8'h3F);
    wr(8'h90, 8'h06);
    rd(8'h83, v); check("R3 segment truncated", v, 8'h15);
  endtask

  task automatic t_map;
    logic [7:0] v;
    cpu_addr_hi_i = 4'h3; #1;
    check("R9 passthru", phys_page_o, 8'h03);
    wr(8'h93, 8'h80);
    check("R8 strobe on enable", {7'd0, clk_recalc_o}, 8'h01);
    check("R6 map on", {7'd0, map_en_o}, 8'h01);
    check("R9 mapped", phys_page_o, 8'h15);
    cpu_addr_hi_i = 4'h4; #1;
    check("R9 mapped empty", phys_page_o, 8'h00);
    @(negedge clk_i);
    check("R8 strobe one cycle", {7'd0, clk_recalc_o}, 8'h00);
    wr(8'h93, 8'h81);
    check("R8 no strobe same map", {7'd0, clk_recalc_o}, 8'h00);
    rd(8'h93, v); check("R7 ctrl read map+boot", v, 8'hBF);
    wr(8'h93, 8'h40);
    check("R8 strobe on disable", {7'd0, clk_recalc_o}, 8'h01);
    rd(8'h93, v); check("R7 R6 ctrl read win", v, 8'h7E);
    #1 check("R9 passthru again", phys_page_o, 8'h04);
  endtask

  task automatic t_window_misc;
    logic [7:0] v;
    wr(8'h92, 8'hA5);
    check("R5 win offset", win_offset_o, 8'hA5);
    rd(8'h91, v); check("R10 unused read", v, 8'hFF);
    rd(8'h90, v); check("R10 seg read", v, 8'hFF);
    wr(8'h13, 8'hFF);
    wr(8'h83, 8'h2A, 1'b0);
    wr(8'h93, 8'h81, 1'b0);
    rd(8'h83, v); check("R10 entry untouched", v, 8'h15);
    rd(8'h93, v); check("R10 ctrl untouched", v, 8'h7E);
    check("R10 win untouched", win_offset_o, 8'hA5);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        t_reset();
        t_entries();
        t_map();
        t_window_misc();
      end
      begin
        repeat (5000) @(posedge clk_i);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule